// File: doc/BRIEF.md
# Debugger Authentication Command Registers

This block is a small register set that only an external debugger can reach. Accesses arrive through a simple write/read port from the debug port. Each access carries the access-port select value, and the block answers only to one select value (255 by default). The registers give the debugger a few system-level levers:

- a system-bus stall;
- a device-wide erase, handed to an outside erase engine;
- a checksum (CRC) request over the user code pages, handed to an outside CRC engine;
- a system reset request, handed to an outside reset controller.

Erase and reset are destructive, so each of them first needs a command key. The key is used up by the next keyed command. Erase must also follow a fixed order: the bus must already be stalled, then the key is written, then the erase bit. After an erase or a CRC request, the debugger must issue a keyed reset request before normal operation resumes. A reset-level input selects what that reset request clears: the whole register space, or only the request bit itself.

Register map (word address on `dp_addr`):

- **Address 0, control.** Bit 0 is the bus stall. Bit 1 is the erase command (keyed). Bit 2 is the CRC command. Bit 3 is the reset request (keyed). A read returns the stall at bit 0 and the live reset request at bit 3.
- **Address 1, key.** It is write-only and reads as 0.
- **Address 2, status.** It is read-only. Bit 0 is erase busy, bit 1 is CRC busy, bit 2 is key armed, and bit 3 is resume pending.

Top module: `dbg_auth_regs`

## Requirements
- R1: Writes take effect and reads return data only when `dp_sel` equals 255. Any other select value leaves every register unchanged and drives `dp_rdata` to 0.
- R2: Writing control bit 0 sets or clears `bus_stall` from the next cycle on. This needs no key and is allowed at any time. The stall holds until it is written to 0.
- R3: A write to the key register with 32'hA5C3_0F96 arms the key, shown in status bit 2. A write with any other value disarms it.
- R4: A control write with bit 1 or bit 3 set while the key is armed disarms the key, whether or not the command is carried out.
- R5: A control write with bit 1 set starts an erase only if all three hold: the key is armed, `bus_stall` was already high before the write, and no erase is busy. `erase_req` and status bit 0 then go high in the next cycle. Otherwise the write leaves them unchanged.
- R6: `erase_req` stays high until `erase_done` is seen high at a clock edge. A further erase write while busy is ignored.
- R7: A control write with bit 2 set while no CRC is busy raises `crc_req` (status bit 1) without a key. `crc_req` stays high until `crc_done` is seen.
- R8: Status bit 3 (resume pending) is set when an erase or a CRC request is accepted. Only a reset request clears it.
- R9: A control write with bit 3 set while the key is armed raises `rst_req` for exactly one cycle. Without the key the write has no effect on `rst_req`.
- R10: In the cycle after `rst_req`, if `rst_full` is high, all state is cleared: stall, erase busy, CRC busy, key and pending. If `rst_full` is low, only the request bit and pending are cleared, and the stall stays as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dp_sel | input | 8 | Access-port select value of the current access |
| dp_addr | input | 2 | Register word address |
| dp_wr | input | 1 | Write strobe, one cycle per write |
| dp_wdata | input | 32 | Write data |
| dp_rdata | output | 32 | Read data for `dp_addr` (combinational) |
| rst_full | input | 1 | Reset level: 1 clears the whole register space on a reset request |
| erase_done | input | 1 | Erase engine completion pulse |
| crc_done | input | 1 | CRC engine completion pulse |
| bus_stall | output | 1 | System-bus stall request |
| erase_req | output | 1 | Erase request to the erase engine (level, equals erase busy) |
| crc_req | output | 1 | CRC request to the CRC engine (level) |
| rst_req | output | 1 | One-cycle system reset request to the reset controller |

## Verification
The erase command is tried in four patterns, and each separates one of the gating conditions:

- the full correct order;
- no key;
- key but no prior stall;
- a second erase while busy.

Key handling is tried with wrong, right and wrong-again values, and with a command that uses the key up, so that arming, disarming and consumption are told apart. A reset request is issued under both reset levels, showing whether the stall and busy state survive. A request is also issued without a key, to show that it does nothing. Writes with a foreign select value confirm that the block stays deaf to them.

// File: rtl/dbg_auth_pkg.sv
// Shared definitions for the debugger authentication command registers:
// register word addresses and bit positions inside the control and status words.
package dbg_auth_pkg;
    typedef enum logic [1:0] {
        ADR_CTRL = 2'd0,
        ADR_KEY  = 2'd1,
        ADR_STAT = 2'd2,
        ADR_RSVD = 2'd3
    } dbg_adr_e;

    localparam int C_STALL = 0;
    localparam int C_ERASE = 1;
    localparam int C_CRC   = 2;
    localparam int C_RESET = 3;
    localparam int CTRL_W  = 4;

    localparam int S_EBUSY = 0;
    localparam int S_CBUSY = 1;
    localparam int S_ARMED = 2;
    localparam int S_PEND  = 3;
    localparam int STAT_W  = 4;
endpackage

// File: rtl/dbg_auth_decode.sv
// Access decode: qualifies a debug-port access by the access-port select value
// and turns the word address into per-register write strobes.
// Assumes dp_wr is a single-cycle strobe and dp_addr is stable with it.
module dbg_auth_decode
    import dbg_auth_pkg::*;
#(
    parameter int SEL_W     = 8,
    parameter int SEL_VALUE = 255
) (
    input  logic [SEL_W-1:0] dp_sel,
    input  logic [1:0]       dp_addr,
    input  logic             dp_wr,
    output logic             sel_ok,
    output logic             wr_ctrl,
    output logic             wr_key
);
    localparam logic [SEL_W-1:0] SEL_MATCH = SEL_W'(SEL_VALUE);

    // Select match and write strobe split.
    always_comb begin
        sel_ok  = (dp_sel == SEL_MATCH);
        wr_ctrl = sel_ok && dp_wr && (dp_addr == ADR_CTRL);
        wr_key  = sel_ok && dp_wr && (dp_addr == ADR_KEY);
    end
endmodule

// File: rtl/dbg_auth_keygate.sv
// Command key gate: arms on a correct key write, disarms on a wrong one,
// on consumption by a keyed command, or on a full register-space clear.
// Assumes consume and wr_key never fire in the same cycle (different addresses).
module dbg_auth_keygate #(
    parameter int          DATA_W    = 32,
    parameter logic [31:0] KEY_VALUE = 32'hA5C3_0F96
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_key,
    input  logic [DATA_W-1:0] wdata,
    input  logic              consume,
    input  logic              clear_all,
    output logic              armed
);
    localparam logic [DATA_W-1:0] KEY_MATCH = DATA_W'(KEY_VALUE);

    logic armed_q;

    // Key armed flag with clear > key write > consumption priority.
    always_ff @(posedge clk) begin
        if (!rst_n)         armed_q <= 1'b0;
        else if (clear_all) armed_q <= 1'b0;
        else if (wr_key)    armed_q <= (wdata == KEY_MATCH);
        else if (consume)   armed_q <= 1'b0;
    end

    assign armed = armed_q;
endmodule

// File: rtl/dbg_auth_cmd.sv
// Command state: bus stall, erase busy, CRC busy, resume-pending and the
// one-cycle reset request, with the key, order and busy gating of each command.
// Assumes erase_done / crc_done are pulses from engines that saw the request.
module dbg_auth_cmd
    import dbg_auth_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic [CTRL_W-1:0] ctrl_bits,
    input  logic              armed,
    input  logic              rst_full,
    input  logic              erase_done,
    input  logic              crc_done,
    output logic              consume,
    output logic              full_clear,
    output logic              stall,
    output logic              erase_busy,
    output logic              crc_busy,
    output logic              pending,
    output logic              rst_req
);
    logic stall_q, ebusy_q, cbusy_q, pend_q, rreq_q;
    logic erase_ok, crc_ok, reset_ok;

    // Command acceptance conditions.
    always_comb begin
        consume    = wr_ctrl && armed && (ctrl_bits[C_ERASE] || ctrl_bits[C_RESET]);
        erase_ok   = wr_ctrl && armed && ctrl_bits[C_ERASE] && stall_q && !ebusy_q;
        crc_ok     = wr_ctrl && ctrl_bits[C_CRC] && !cbusy_q;
        reset_ok   = wr_ctrl && armed && ctrl_bits[C_RESET] && !rreq_q;
        full_clear = rreq_q && rst_full;
    end

    // Command state registers.
    always_ff @(posedge clk) begin
        if (!rst_n || full_clear) begin
            stall_q <= 1'b0;
            ebusy_q <= 1'b0;
            cbusy_q <= 1'b0;
            pend_q  <= 1'b0;
            rreq_q  <= 1'b0;
        end else begin
            rreq_q <= reset_ok;
            if (wr_ctrl) stall_q <= ctrl_bits[C_STALL];
            if (erase_ok)        ebusy_q <= 1'b1;
            else if (erase_done) ebusy_q <= 1'b0;
            if (crc_ok)          cbusy_q <= 1'b1;
            else if (crc_done)   cbusy_q <= 1'b0;
            if (erase_ok || crc_ok) pend_q <= 1'b1;
            else if (rreq_q)        pend_q <= 1'b0;
        end
    end

    assign stall      = stall_q;
    assign erase_busy = ebusy_q;
    assign crc_busy   = cbusy_q;
    assign pending    = pend_q;
    assign rst_req    = rreq_q;
endmodule

// File: rtl/dbg_auth_regs.sv
// Top of the debugger authentication command registers: decode, key gate,
// command state and the read mux. Reachable only through the debug port.
// Assumes a single debugger master; reads are combinational on dp_addr.
module dbg_auth_regs
    import dbg_auth_pkg::*;
#(
    parameter int          DATA_W    = 32,
    parameter int          SEL_W     = 8,
    parameter int          SEL_VALUE = 255,
    parameter logic [31:0] KEY_VALUE = 32'hA5C3_0F96
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  dp_sel,
    input  logic [1:0]        dp_addr,
    input  logic              dp_wr,
    input  logic [DATA_W-1:0] dp_wdata,
    output logic [DATA_W-1:0] dp_rdata,
    input  logic              rst_full,
    input  logic              erase_done,
    input  logic              crc_done,
    output logic              bus_stall,
    output logic              erase_req,
    output logic              crc_req,
    output logic              rst_req
);
    logic sel_ok, wr_ctrl, wr_key;
    logic armed, consume, full_clear, pending;
    logic [CTRL_W-1:0] ctrl_rd;
    logic [STAT_W-1:0] stat_rd;

    dbg_auth_decode #(.SEL_W(SEL_W), .SEL_VALUE(SEL_VALUE)) u_dec (
        .dp_sel(dp_sel), .dp_addr(dp_addr), .dp_wr(dp_wr),
        .sel_ok(sel_ok), .wr_ctrl(wr_ctrl), .wr_key(wr_key)
    );

    dbg_auth_keygate #(.DATA_W(DATA_W), .KEY_VALUE(KEY_VALUE)) u_key (
        .clk(clk), .rst_n(rst_n), .wr_key(wr_key), .wdata(dp_wdata),
        .consume(consume), .clear_all(full_clear), .armed(armed)
    );

    dbg_auth_cmd u_cmd (
        .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl),
        .ctrl_bits(dp_wdata[CTRL_W-1:0]), .armed(armed), .rst_full(rst_full),
        .erase_done(erase_done), .crc_done(crc_done),
        .consume(consume), .full_clear(full_clear),
        .stall(bus_stall), .erase_busy(erase_req), .crc_busy(crc_req),
        .pending(pending), .rst_req(rst_req)
    );

    // Read word assembly for control and status views.
    always_comb begin
        ctrl_rd          = '0;
        ctrl_rd[C_STALL] = bus_stall;
        ctrl_rd[C_RESET] = rst_req;
        stat_rd          = '0;
        stat_rd[S_EBUSY] = erase_req;
        stat_rd[S_CBUSY] = crc_req;
        stat_rd[S_ARMED] = armed;
        stat_rd[S_PEND]  = pending;
    end

    // Read mux, silent unless the select value matches.
    always_comb begin
        dp_rdata = '0;
        if (sel_ok) begin
            unique case (dp_addr)
                ADR_CTRL: dp_rdata = DATA_W'(ctrl_rd);
                ADR_STAT: dp_rdata = DATA_W'(stat_rd);
                default:  dp_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/dbg_auth_chk.sv
// Property checker for dbg_auth_regs, attached by bind. Observes ports only.
module dbg_auth_chk #(
    parameter int DATA_W    = 32,
    parameter int SEL_W     = 8,
    parameter int SEL_VALUE = 255
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SEL_W-1:0]  dp_sel,
    input logic              dp_wr,
    input logic [DATA_W-1:0] dp_rdata,
    input logic              rst_full,
    input logic              erase_done,
    input logic              bus_stall,
    input logic              erase_req,
    input logic              crc_req,
    input logic              rst_req
);
    localparam logic [SEL_W-1:0] SEL_MATCH = SEL_W'(SEL_VALUE);

    // R1: foreign-select accesses read as zero.
    always_comb begin
        if (rst_n && dp_sel != SEL_MATCH)
            a_r1_quiet_read: assert (dp_rdata == '0);
    end

    a_r1_foreign_write: assert property (@(posedge clk) disable iff (!rst_n)
        dp_wr && dp_sel != SEL_MATCH && !rst_req |=>
            $stable(bus_stall) && !$rose(erase_req) && !$rose(crc_req) && !$rose(rst_req));

    a_r5_erase_after_stall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(erase_req) |-> $past(bus_stall));

    a_r6_erase_held: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req && !erase_done && !(rst_req && rst_full) |=> erase_req);

    a_r9_reset_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    a_r10_full_clear: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req && rst_full |=> !bus_stall && !erase_req && !crc_req);
endmodule

bind dbg_auth_regs dbg_auth_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W), .SEL_VALUE(SEL_VALUE)) u_chk (.*);

// File: tb/sim_dbg_auth_regs.sv
// Directed bench for dbg_auth_regs: one task per scenario, each self-checking.
module sim_dbg_auth_regs;
    localparam logic [31:0] KEY = 32'hA5C3_0F96;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  dp_sel = 8'd255;
    logic [1:0]  dp_addr = 2'd0;
    logic        dp_wr = 1'b0;
    logic [31:0] dp_wdata = '0;
    logic [31:0] dp_rdata;
    logic        rst_full = 1'b0;
    logic        erase_done = 1'b0;
    logic        crc_done = 1'b0;
    logic        bus_stall, erase_req, crc_req, rst_req;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dbg_auth_regs u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [7:0] s = 8'd255);
        @(negedge clk);
        dp_sel = s; dp_addr = a; dp_wdata = d; dp_wr = 1'b1;
        @(negedge clk);
        dp_wr = 1'b0; dp_sel = 8'd255;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d, input logic [7:0] s = 8'd255);
        dp_sel = s; dp_addr = a;
        #0.5;
        d = dp_rdata;
        dp_sel = 8'd255;
    endtask

    task automatic pulse_erase_done();
        @(negedge clk); erase_done = 1'b1;
        @(negedge clk); erase_done = 1'b0;
    endtask

    task automatic pulse_crc_done();
        @(negedge clk); crc_done = 1'b1;
        @(negedge clk); crc_done = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        chk("R2 stall after reset", 32'(bus_stall), 0);
        chk("R6 erase_req after reset", 32'(erase_req), 0);
        rd(2'd2, d);
        chk("R8 status after reset", d, 0);
    endtask

    task automatic t_select();
        logic [31:0] d;
        wr(2'd0, 32'h1, 8'd254);
        chk("R1 foreign stall write", 32'(bus_stall), 0);
        wr(2'd1, KEY, 8'd0);
        rd(2'd2, d);
        chk("R1 foreign key write", d, 0);
        wr(2'd0, 32'h1);
        rd(2'd0, d, 8'd254);
        chk("R1 foreign read zero", d, 0);
        rd(2'd0, d);
        chk("R1 matching read", d, 32'h1);
        wr(2'd0, 32'h0);
    endtask

    task automatic t_stall();
        wr(2'd0, 32'h1);
        chk("R2 stall set", 32'(bus_stall), 1);
        repeat (3) @(negedge clk);
        chk("R2 stall held", 32'(bus_stall), 1);
        wr(2'd0, 32'h0);
        chk("R2 stall cleared", 32'(bus_stall), 0);
    endtask

    task automatic t_key();
        logic [31:0] d;
        wr(2'd1, KEY ^ 32'h1);
        rd(2'd2, d); chk("R3 wrong key", d[2], 0);
        wr(2'd1, KEY);
        rd(2'd2, d); chk("R3 right key", d[2], 1);
        wr(2'd1, 32'h0);
        rd(2'd2, d); chk("R3 wrong key disarms", d[2], 0);
        wr(2'd0, 32'h1);
        wr(2'd0, 32'h3);
        chk("R5 erase without key", 32'(erase_req), 0);
        wr(2'd0, 32'h0);
    endtask

    task automatic t_erase_order();
        logic [31:0] d;
        wr(2'd1, KEY);
        wr(2'd0, 32'h3);
        chk("R5 erase without prior stall", 32'(erase_req), 0);
        rd(2'd2, d); chk("R4 key consumed by rejected erase", d[2], 0);
        wr(2'd0, 32'h0);
    endtask

    task automatic t_erase();
        logic [31:0] d;
        wr(2'd0, 32'h1);
        wr(2'd1, KEY);
        wr(2'd0, 32'h3);
        chk("R5 erase accepted", 32'(erase_req), 1);
        rd(2'd2, d);
        chk("R5 busy and pending, key consumed", d, 32'h9);
        wr(2'd1, KEY);
        wr(2'd0, 32'h3);
        rd(2'd2, d);
        chk("R6 erase while busy ignored, key consumed", d, 32'h9);
        repeat (4) @(negedge clk);
        chk("R6 erase held", 32'(erase_req), 1);
        pulse_erase_done();
        chk("R6 erase done", 32'(erase_req), 0);
        rd(2'd2, d); chk("R8 pending kept", d, 32'h8);
    endtask

    task automatic t_reset_partial();
        logic [31:0] d;
        rst_full = 1'b0;
        wr(2'd0, 32'h9);
        chk("R9 unkeyed reset ignored", 32'(rst_req), 0);
        wr(2'd1, KEY);
        wr(2'd0, 32'h9);
        chk("R9 reset request high", 32'(rst_req), 1);
        @(negedge clk);
        chk("R9 reset request one cycle", 32'(rst_req), 0);
        chk("R10 partial keeps stall", 32'(bus_stall), 1);
        rd(2'd2, d); chk("R8 pending cleared by reset", d, 0);
    endtask

    task automatic t_crc();
        logic [31:0] d;
        wr(2'd0, 32'h5);
        chk("R7 crc request", 32'(crc_req), 1);
        rd(2'd2, d); chk("R8 crc sets pending", d, 32'hA);
        pulse_crc_done();
        chk("R7 crc done", 32'(crc_req), 0);
        wr(2'd0, 32'h5);
        chk("R7 crc again", 32'(crc_req), 1);
    endtask

    task automatic t_reset_full();
        logic [31:0] d;
        rst_full = 1'b1;
        wr(2'd1, KEY);
        wr(2'd0, 32'h9);
        chk("R9 keyed reset", 32'(rst_req), 1);
        @(negedge clk);
        chk("R10 full clears stall", 32'(bus_stall), 0);
        chk("R10 full clears crc", 32'(crc_req), 0);
        rd(2'd2, d); chk("R10 full clears status", d, 0);
        rst_full = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_select();
        t_stall();
        t_key();
        t_erase_order();
        t_erase();
        t_reset_partial();
        t_crc();
        t_reset_full();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule